// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one low-speed USB packet onto the bus. A single-cycle start request launches the packet. The block then presets the lines to the idle J level and takes the bus. It sends the sync byte and each payload byte least significant bit first. The bit stream is NRZI-coded, and a stuffed bit is inserted after every run of six ones. The packet closes with a timed SE0 end-of-packet and one J cell, after which the bus is released. Payload bytes are fetched through a small read port: the block presents a byte index, and the source answers combinationally in the same cycle.

A second mode sends a two-byte handshake packet. This packet holds only the sync byte and a PID taken from a dedicated input, and the read port is not used. The block also keeps the device's active address. A pending address given on an input becomes active when a data packet finishes. A handshake never changes the active address. CRC generation and the choice of response belong to the surrounding logic.

Top module: `usb_ls_tx`

## Requirements
- R1: On an accepted start, the block spends exactly one cycle with `oe_o` low and the lines at J (`dp_o`=0, `dm_o`=1) before it asserts `oe_o`.
- R2: The first byte on the wire is the sync byte 0x80. It is followed by the payload bytes in index order 0, 1, 2 …, each sent least significant bit first. Payload byte k is read from `rd_data_i` while `rd_addr_o` equals k.
- R3: Each bit cell lasts `BIT_CYC` (8) clock cycles. A 0 bit toggles the lines and a 1 bit keeps them. J is `dp_o`=0/`dm_o`=1, K is `dp_o`=1/`dm_o`=0, and the first cell is coded relative to J. Both lines are never high together.
- R4: After six consecutive 1 bits on the wire, a stuffed 0 (one toggle) is inserted. The count of ones carries across byte boundaries, and a stuffed bit also follows the last payload bit when that bit completes a run of six.
- R5: In data mode, `len_i` gives the total packet length including the sync byte. A start with `len_i` outside 2..12 is ignored, and `oe_o` stays low.
- R6: After the last cell (data or stuffed), the block drives SE0 (both lines low, `oe_o` high) for two bit cells, then J for one bit cell, and then drops `oe_o`.
- R7: With `hs_i`=1, the packet is the sync byte followed by `hs_pid_i`, whatever the value of `len_i`.
- R8: `done_o` is high for exactly one cycle: the first cycle in which `oe_o` is low after a packet.
- R9: `addr_o` is 0 after reset. It takes the value of `new_addr_i` only when a data packet finishes, in the cycle where `done_o` is high. A handshake packet leaves it unchanged.
- R10: A start request that arrives while a packet is being sent is ignored. The packet in flight is unchanged, and no second packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| hs_i | input | 1 | 1 = handshake packet, 0 = data packet |
| len_i | input | 4 | Total bytes including sync (data mode) |
| hs_pid_i | input | 8 | PID byte for a handshake packet |
| rd_addr_o | output | 4 | Index of the payload byte requested |
| rd_data_i | input | 8 | Payload byte at `rd_addr_o`, combinational |
| new_addr_i | input | 7 | Pending device address |
| addr_o | output | 7 | Active device address |
| dp_o | output | 1 | D+ drive level |
| dm_o | output | 1 | D- drive level |
| oe_o | output | 1 | Bus output enable |
| done_o | output | 1 | Packet finished, one-cycle pulse |

## Verification
The assertions watch several properties on every cycle. They check that the lines sit at J in the cycle before the output enable rises, and that SE0 is always followed by the J cell. They check that the run-of-ones counter never exceeds six and that no SE1 level ever appears. They also check that `done_o` coincides with the release of the bus, that the address moves only at the end of a data packet, and that no new packet can be prepared while one is running. The actual content of the wire is shown only by the bench's scenarios. These scenarios cover the cell-by-cell NRZI levels, the placement of stuffed bits across byte edges and after the final bit, the length of each packet, and the handshake PID. The bench sweeps every legal length against patterns with heavy, light and no stuffing.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DATA,
    ST_SE0,
    ST_EOPJ
  } tx_st_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/usb_ls_tx_enc.sv
module usb_ls_tx_enc #(
  parameter int RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  input  logic bit_i,
  output logic stuff_o,
  output logic k_o
);
  localparam int OW = $clog2(RUN + 1);
  localparam logic [OW-1:0] RUN_V = OW'(RUN);

  logic [OW-1:0] ones_q;
  logic          k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      k_q    <= 1'b0;
    end else if (clear_i) begin
      ones_q <= '0;
      k_q    <= 1'b0;
    end else if (tick_i) begin
      if (ones_q == RUN_V) begin
        ones_q <= '0;
        k_q    <= ~k_q;
      end else if (bit_i) begin
        ones_q <= ones_q + OW'(1);
      end else begin
        ones_q <= '0;
        k_q    <= ~k_q;
      end
    end
  end

  assign stuff_o = (ones_q == RUN_V);
  assign k_o     = k_q;

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= RUN_V); // R4
  AST_ONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clear_i && !stuff_o && bit_i) |=> $stable(k_o)); // R3
endmodule

// File: rtl/usb_ls_tx_ctrl.sv
module usb_ls_tx_ctrl
  import usb_ls_tx_pkg::*;
#(
  parameter int BIT_CYC   = 8,
  parameter int MAX_BYTES = 12,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1),
  parameter int AW        = $clog2(MAX_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hs_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       pid_i,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [7:0]       rd_data_i,
  input  logic             stuff_i,
  output logic             tick_o,
  output logic             bit_o,
  output logic             clear_o,
  output tx_st_e           st_o,
  output logic             fin_o,
  output logic             hs_o
);
  localparam int CW = $clog2(2 * BIT_CYC);
  localparam logic [CW-1:0] BIT_END = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] SE0_END = CW'(2 * BIT_CYC - 1);

  tx_st_e           st_q;
  logic [CW-1:0]    cyc_q;
  logic [7:0]       sh_q;
  logic [2:0]       bi_q;
  logic [LEN_W-1:0] byt_q, last_q;
  logic             all_out_q, hs_q;
  logic [7:0]       pid_q;
  logic             len_ok, accept, more;

  assign len_ok  = (len_i >= LEN_W'(2)) && (len_i <= LEN_W'(MAX_BYTES));
  assign accept  = (st_q == ST_IDLE) && start_i && (hs_i || len_ok);
  assign more    = stuff_i || !all_out_q;
  assign tick_o  = (st_q == ST_PREP) ||
                   ((st_q == ST_DATA) && (cyc_q == BIT_END) && more);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cyc_q     <= '0;
      sh_q      <= '0;
      bi_q      <= '0;
      byt_q     <= '0;
      last_q    <= '0;
      all_out_q <= 1'b0;
      hs_q      <= 1'b0;
      pid_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q      <= ST_PREP;
          cyc_q     <= '0;
          sh_q      <= SYNC_BYTE;
          bi_q      <= '0;
          byt_q     <= '0;
          all_out_q <= 1'b0;
          hs_q      <= hs_i;
          pid_q     <= pid_i;
          last_q    <= hs_i ? LEN_W'(1) : len_i - LEN_W'(1);
        end
        ST_PREP: begin
          st_q  <= ST_DATA;
          cyc_q <= '0;
        end
        ST_DATA: if (cyc_q == BIT_END) begin
          cyc_q <= '0;
          if (!more) st_q <= ST_SE0;
        end else cyc_q <= cyc_q + CW'(1);
        ST_SE0: if (cyc_q == SE0_END) begin
          cyc_q <= '0;
          st_q  <= ST_EOPJ;
        end else cyc_q <= cyc_q + CW'(1);
        ST_EOPJ: if (cyc_q == BIT_END) begin
          cyc_q <= '0;
          st_q  <= ST_IDLE;
        end else cyc_q <= cyc_q + CW'(1);
        default: st_q <= ST_IDLE;
      endcase
      // advance the byte shifter only on real data bits, not on stuffed ones
      if (tick_o && !stuff_i) begin
        if (bi_q == 3'd7) begin
          bi_q <= '0;
          if (byt_q == last_q) all_out_q <= 1'b1;
          else begin
            sh_q  <= hs_q ? pid_q : rd_data_i;
            byt_q <= byt_q + LEN_W'(1);
          end
        end else begin
          sh_q <= {1'b0, sh_q[7:1]};
          bi_q <= bi_q + 3'd1;
        end
      end
    end
  end

  assign rd_addr_o = byt_q[AW-1:0];
  assign bit_o     = sh_q[0];
  assign clear_o   = accept;
  assign st_o      = st_q;
  assign fin_o     = (st_q == ST_EOPJ) && (cyc_q == BIT_END);
  assign hs_o      = hs_q;

  AST_SE0_THEN_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_SE0 && st_q != ST_SE0) |-> st_q == ST_EOPJ); // R6
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> st_q != ST_PREP); // R10
  AST_SE0_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SE0 && $past(st_q) != ST_SE0) |-> $past(st_q) == ST_DATA); // R6
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int BIT_CYC   = 8,
  parameter int MAX_BYTES = 12,
  parameter int RUN       = 6,
  parameter int ADDR_W    = 7,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1),
  parameter int AW        = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hs_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [7:0]        hs_pid_i,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              done_o
);
  tx_st_e st;
  logic   tick, bit_v, clear, stuff, k_lvl, fin, hs_q;
  logic   done_q;
  logic [ADDR_W-1:0] addr_q;

  usb_ls_tx_ctrl #(
    .BIT_CYC(BIT_CYC), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .AW(AW)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .hs_i(hs_i),
    .len_i(len_i), .pid_i(hs_pid_i), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .stuff_i(stuff), .tick_o(tick), .bit_o(bit_v),
    .clear_o(clear), .st_o(st), .fin_o(fin), .hs_o(hs_q)
  );

  usb_ls_tx_enc #(.RUN(RUN)) u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .tick_i(tick),
    .bit_i(bit_v), .stuff_o(stuff), .k_o(k_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= fin;
      if (fin && !hs_q) addr_q <= new_addr_i;
    end
  end

  assign oe_o   = (st == ST_DATA) || (st == ST_SE0) || (st == ST_EOPJ);
  assign dp_o   = (st == ST_DATA) && k_lvl;
  assign dm_o   = ((st == ST_DATA) && !k_lvl) || (st == ST_PREP) || (st == ST_EOPJ);
  assign done_o = done_q;
  assign addr_o = addr_q;

  AST_J_BEFORE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(dm_o && !dp_o && !oe_o)); // R1
  AST_NO_SE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_o && dm_o)); // R3
  AST_DONE_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> done_o); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ADDR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> (done_o && !hs_q)); // R9
endmodule

// File: tb/sim_usb_ls_tx.sv
`timescale 1ns/1ps
module sim_usb_ls_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, hs = 1'b0;
  logic [3:0] len = '0;
  logic [7:0] pid = '0;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic [6:0] new_addr = '0;
  logic [6:0] addr;
  logic       dp, dm, oe, done;
  logic [7:0] mem [0:15];
  logic       exp_k [0:255];
  int         n_cells;
  int         checks = 0, fails = 0;
  logic [6:0] cur_addr;

  always #2.5 clk = ~clk;
  assign rd_data = mem[rd_addr];

  usb_ls_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hs_i(hs), .len_i(len),
    .hs_pid_i(pid), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .new_addr_i(new_addr), .addr_o(addr), .dp_o(dp), .dm_o(dm),
    .oe_o(oe), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected NRZI levels: sync + payload LSB first, stuff after six ones
  task automatic build(input int nbytes, input bit use_hs, input logic [7:0] p);
    int ones = 0;
    logic k = 1'b0;
    n_cells = 0;
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] v;
      v = (b == 0) ? 8'h80 : (use_hs ? p : mem[b-1]);
      for (int i = 0; i < 8; i++) begin
        if (v[i]) ones++;
        else begin ones = 0; k = ~k; end
        exp_k[n_cells] = k; n_cells++;
        if (ones == 6) begin k = ~k; exp_k[n_cells] = k; n_cells++; ones = 0; end
      end
    end
  endtask

  task automatic send(input int total, input bit use_hs, input logic [7:0] p,
                      input logic [6:0] na, input bit poke_busy);
    build(use_hs ? 2 : total, use_hs, p);
    @(negedge clk);
    start = 1'b1; hs = use_hs; len = use_hs ? 4'd0 : 4'(total); pid = p; new_addr = na;
    @(posedge clk); #1;
    start = 1'b0;
    chk(!oe && !dp && dm, "R1", {oe, dp, dm}, 3'b001);
    @(posedge clk);
    for (int c = 0; c < n_cells; c++) begin
      repeat (4) @(posedge clk);
      #1;
      chk(oe && dp == exp_k[c] && dm == !exp_k[c], "R2,R3,R4",
          {oe, dp, dm}, {1'b1, exp_k[c], !exp_k[c]});
      if (poke_busy && c == 3) begin start = 1'b1; hs = 1'b1; len = 4'd5; end
      if (poke_busy && c == 4) start = 1'b0;
      repeat (4) @(posedge clk);
    end
    for (int c = 0; c < 3; c++) begin
      repeat (4) @(posedge clk);
      #1;
      if (c < 2) chk(oe && !dp && !dm, "R6", {oe, dp, dm}, 3'b100);
      else       chk(oe && !dp && dm, "R6", {oe, dp, dm}, 3'b101);
      repeat (4) @(posedge clk);
    end
    #1;
    chk(!oe && done, "R8", {oe, done}, 2'b01);
    if (!use_hs) cur_addr = na;
    chk(addr == cur_addr, "R9", addr, cur_addr);
    @(posedge clk); #1;
    chk(!done, "R8", done, 0);
  endtask

  task automatic quiet(input int cycles, input string req);
    bit bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (oe || done) bad = 1;
    end
    chk(!bad, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cur_addr = '0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(!oe && !done && addr == 0, "R9", {oe, done, addr}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!oe && !dp && !dm && !done, "R8", {oe, dp, dm, done}, 0);

    // sweep all legal lengths over several payload patterns
    for (int l = 2; l <= 12; l++) begin
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < 16; i++) begin
          case (p)
            0: mem[i] = 8'hFF;
            1: mem[i] = 8'h00;
            2: mem[i] = 8'(i * 37 + l * 11);
            default: mem[i] = (i % 2) ? 8'hFC : 8'h3F;
          endcase
        end
        send(l, 1'b0, 8'h00, 7'(l * 4 + p), 1'b0);
      end
    end

    // R7: handshake ignores len_i and payload, keeps address
    for (int i = 0; i < 16; i++) mem[i] = 8'h55;
    send(0, 1'b1, 8'hD2, 7'h7F, 1'b0);
    send(0, 1'b1, 8'h5A, 7'h11, 1'b0);
    send(0, 1'b1, 8'h1E, 7'h22, 1'b0);
    send(0, 1'b1, 8'hFF, 7'h33, 1'b0);

    // R5: illegal lengths are ignored
    for (int bad = 0; bad < 16; bad++) begin
      if (bad < 2 || bad > 12) begin
        @(negedge clk);
        start = 1'b1; hs = 1'b0; len = 4'(bad);
        @(negedge clk);
        start = 1'b0;
        quiet(12, "R5");
      end
    end

    // R10: start mid-packet is ignored
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'hA5 ^ i);
    send(6, 1'b0, 8'h00, 7'h2C, 1'b1);
    quiet(40, "R10");

    // R9: data packet after handshake still updates address
    send(3, 1'b0, 8'h00, 7'h05, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule